// File: doc/BRIEF.md
# Backup Charge Timer with Test Bypass

This block is the time base of a fast-charge controller. A single master clock drives a synchronous divider chain. The chain produces three things: a square-wave system clock for the voltage-to-frequency converter, a one-cycle tick that starts each battery sampling window, and a flag that goes high once the holdoff period after a restart has run out. A separate long chain measures fast-charge time against a limit picked by a 3-bit selection code. When the limit is reached it raises a timeout flag that stays set.

Verifying a chain whose full span is hours would take too long, so the block has stage-bypass switches. These are entered through input conditions the charger already has. The flag that says the sense voltage is below its window makes the timer skip its coarse group of stages. Adding the test-level flag also skips the fine group. The test-level flag on its own shortens the sample and holdoff dividers. A restart pulse (the sense voltage re-entering its window, or the supply leaving lockout) clears the timer, the timeout latch and the holdoff divider. It leaves the system clock and the sample timing running.

Top module: `chg_backup_timer`

## Requirements
- R1: While `rst_i` is high, `sysclk_o`, `sample_o`, `holdoff_o` and `timeout_o` are all low.
- R2: `sysclk_o` is a square wave with a period of 2^PRE_W master cycles and a 50% duty cycle.
- R3: `sample_o` is a one-cycle pulse repeating every 2^(PRE_W+GATE_LO_W+GATE_TST_W) cycles; with `testlvl_i` high the period is 2^(PRE_W+GATE_LO_W).
- R4: After a restart, `holdoff_o` rises after 2^(PRE_W+HOLD_LO_W+HOLD_TST_W) cycles (within one system-clock period), or after 2^(PRE_W+HOLD_LO_W) cycles with `testlvl_i` high, and then stays high until the next restart.
- R5: For `tsel_i` = k (binary, 1 to 7), `timeout_o` is first high after edge (k+1)·U+1, counting the edge that samples `restart_i` as edge 0, where the unit U is 2^(FINE_W+COARSE_W) in normal operation.
- R6: With `tsel_i` = 0 the timer is disabled and `timeout_o` never rises.
- R7: `timeout_o` stays high once set, even if `tsel_i` changes, until a restart; the edge that samples `restart_i` high clears it.
- R8: With `below_i` high and `testlvl_i` low, the coarse group is bypassed and the unit U is 2^FINE_W cycles.
- R9: With `below_i` and `testlvl_i` both high, both groups are bypassed and U is one cycle; `testlvl_i` alone leaves U at its normal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Restart pulse: clears the timer, the timeout latch and the holdoff divider |
| below_i | input | 1 | Sense voltage below its window; selects coarse bypass |
| testlvl_i | input | 1 | Test-level flag; shortens the gate and holdoff dividers and, with `below_i`, the fine group |
| tsel_i | input | 3 | Time limit code; 0 disables the timer |
| sysclk_o | output | 1 | Divided system clock |
| sample_o | output | 1 | One-cycle tick that starts a sampling window |
| holdoff_o | output | 1 | Holdoff period has elapsed since the last restart |
| timeout_o | output | 1 | Latched fast-charge time limit reached |

## Verification
On every cycle the assertions check that the sample tick is never longer than one cycle and that a rising system clock stays high for at least a second cycle. They also check that the holdoff and timeout flags hold once set, that a restart clears both, that a zero code never sets the timeout, and that the unit counter never runs past its largest limit. The bench scenarios show the exact number of cycles from restart to timeout for each bypass combination and several codes, and the sample and holdoff periods in normal and test modes. Those scenarios also show that the test-level flag alone leaves the timer at full length.

// File: rtl/chg_timer_pkg.sv
package chg_timer_pkg;

  typedef struct packed {
    logic skip_coarse;  // coarse timer group bypassed
    logic skip_fine;    // fine timer group bypassed
    logic fast_gate;    // gate and holdoff test groups bypassed
  } bypass_t;

  function automatic bypass_t decode_bypass(input logic below, input logic tlvl);
    bypass_t b;
    b.skip_coarse = below;
    b.skip_fine   = below & tlvl;
    b.fast_gate   = tlvl;
    return b;
  endfunction

endpackage

// File: rtl/chg_div_seg.sv
module chg_div_seg #(
  parameter int unsigned W = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic tick_i,
  input  logic skip_i,
  output logic carry_o
);

  logic [W-1:0] cnt_q;

  // a bypassed group passes its input tick straight through
  assign carry_o = tick_i & (skip_i | (&cnt_q));

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i || skip_i) cnt_q <= '0;
    else if (tick_i)              cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/chg_bypass_ctrl.sv
module chg_bypass_ctrl
  import chg_timer_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  logic    below_i,
  input  logic    testlvl_i,
  output bypass_t sw_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) sw_o <= '0;
    else       sw_o <= decode_bypass(below_i, testlvl_i);
  end

endmodule

// File: rtl/chg_limit_timer.sv
module chg_limit_timer #(
  parameter int unsigned FINE_W   = 11,
  parameter int unsigned COARSE_W = 19,
  parameter int unsigned UNIT_W   = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       restart_i,
  input  logic [2:0] tsel_i,
  input  logic       skip_fine_i,
  input  logic       skip_coarse_i,
  output logic       timeout_o
);

  localparam logic [UNIT_W-1:0] UNIT_MAX = UNIT_W'(8);

  logic [UNIT_W-1:0] units_q;
  logic [UNIT_W-1:0] lim;
  logic              enabled;
  logic              run;
  logic              fine_carry;
  logic              coarse_carry;

  assign lim     = UNIT_W'(tsel_i) + UNIT_W'(1);
  assign enabled = (tsel_i != 3'd0);
  assign run     = enabled && !timeout_o && (units_q < lim);

  chg_div_seg #(.W(FINE_W)) u_fine (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clr_i   (restart_i),
    .tick_i  (run),
    .skip_i  (skip_fine_i),
    .carry_o (fine_carry)
  );

  chg_div_seg #(.W(COARSE_W)) u_coarse (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clr_i   (restart_i),
    .tick_i  (fine_carry),
    .skip_i  (skip_coarse_i),
    .carry_o (coarse_carry)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) units_q <= '0;
    else if (coarse_carry)  units_q <= units_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i)          timeout_o <= 1'b0;
    else if (enabled && units_q >= lim) timeout_o <= 1'b1;
  end

  assert_timeout_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (timeout_o && !restart_i) |=> timeout_o);

  assert_disabled_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!timeout_o && tsel_i == 3'd0) |=> !timeout_o);

  assert_unit_bound_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    units_q <= UNIT_MAX);

endmodule

// File: rtl/chg_backup_timer.sv
module chg_backup_timer
  import chg_timer_pkg::*;
#(
  parameter int unsigned PRE_W      = 3,
  parameter int unsigned GATE_LO_W  = 12,
  parameter int unsigned GATE_TST_W = 5,
  parameter int unsigned HOLD_LO_W  = 13,
  parameter int unsigned HOLD_TST_W = 11,
  parameter int unsigned FINE_W     = 11,
  parameter int unsigned COARSE_W   = 19,
  parameter int unsigned UNIT_W     = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       restart_i,
  input  logic       below_i,
  input  logic       testlvl_i,
  input  logic [2:0] tsel_i,
  output logic       sysclk_o,
  output logic       sample_o,
  output logic       holdoff_o,
  output logic       timeout_o
);

  localparam int unsigned TIMER_STAGES = FINE_W + COARSE_W + UNIT_W;
  localparam int unsigned SAMPLE_LOG   = PRE_W + GATE_LO_W + GATE_TST_W;

  bypass_t          sw;
  logic [PRE_W-1:0] pre_q;
  logic             pre_carry;
  logic             gate_lo_carry;
  logic             gate_carry;
  logic             hold_lo_carry;
  logic             hold_carry;

  chg_bypass_ctrl u_bypass (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .below_i   (below_i),
    .testlvl_i (testlvl_i),
    .sw_o      (sw)
  );

  // system clock prescaler, never restarted
  always_ff @(posedge clk_i) begin
    if (rst_i) pre_q <= '0;
    else       pre_q <= pre_q + 1'b1;
  end
  assign pre_carry = &pre_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sysclk_o <= 1'b0;
    else       sysclk_o <= pre_q[PRE_W-1];
  end

  // sample-cycle divider
  chg_div_seg #(.W(GATE_LO_W)) u_gate_lo (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clr_i   (1'b0),
    .tick_i  (pre_carry),
    .skip_i  (1'b0),
    .carry_o (gate_lo_carry)
  );

  chg_div_seg #(.W(GATE_TST_W)) u_gate_tst (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clr_i   (1'b0),
    .tick_i  (gate_lo_carry),
    .skip_i  (sw.fast_gate),
    .carry_o (gate_carry)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) sample_o <= 1'b0;
    else       sample_o <= gate_carry;
  end

  // holdoff divider, restarted with the timer
  chg_div_seg #(.W(HOLD_LO_W)) u_hold_lo (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clr_i   (restart_i),
    .tick_i  (pre_carry),
    .skip_i  (1'b0),
    .carry_o (hold_lo_carry)
  );

  chg_div_seg #(.W(HOLD_TST_W)) u_hold_tst (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clr_i   (restart_i),
    .tick_i  (hold_lo_carry),
    .skip_i  (sw.fast_gate),
    .carry_o (hold_carry)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) holdoff_o <= 1'b0;
    else if (hold_carry)    holdoff_o <= 1'b1;
  end

  chg_limit_timer #(
    .FINE_W   (FINE_W),
    .COARSE_W (COARSE_W),
    .UNIT_W   (UNIT_W)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .restart_i     (restart_i),
    .tsel_i        (tsel_i),
    .skip_fine_i   (sw.skip_fine),
    .skip_coarse_i (sw.skip_coarse),
    .timeout_o     (timeout_o)
  );

  initial begin
    if (TIMER_STAGES < 6 || SAMPLE_LOG < 2 || PRE_W < 2 || UNIT_W < 4)
      $error("chg_backup_timer: stage widths too small");
  end

  assert_sample_pulse_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_o |=> !sample_o);

  assert_sysclk_width_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sysclk_o) |=> sysclk_o);

  assert_holdoff_sticky_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (holdoff_o && !restart_i) |=> holdoff_o);

  assert_restart_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> (!timeout_o && !holdoff_o));

endmodule

// File: tb/chg_backup_timer_test.sv
module chg_backup_timer_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       restart;
  logic       below;
  logic       testlvl;
  logic [2:0] tsel;
  logic       sysclk_o, sample_o, holdoff_o, timeout_o;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  // small stage counts so every path is reachable in the run
  chg_backup_timer #(
    .PRE_W(3), .GATE_LO_W(4), .GATE_TST_W(2),
    .HOLD_LO_W(2), .HOLD_TST_W(3),
    .FINE_W(3), .COARSE_W(4), .UNIT_W(4)
  ) uut (
    .clk_i(clk), .rst_i(rst), .restart_i(restart),
    .below_i(below), .testlvl_i(testlvl), .tsel_i(tsel),
    .sysclk_o(sysclk_o), .sample_o(sample_o),
    .holdoff_o(holdoff_o), .timeout_o(timeout_o)
  );

  // {below, testlvl, code[2:0], expected edges to timeout[10:0]}
  // units: normal 128, coarse skipped 8, both skipped 1
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 1'b0, 3'd1, 11'd257},  // R5
    {1'b0, 1'b0, 3'd3, 11'd513},  // R5
    {1'b1, 1'b0, 3'd2, 11'd25},   // R8
    {1'b1, 1'b0, 3'd7, 11'd65},   // R8
    {1'b1, 1'b1, 3'd4, 11'd6},    // R9
    {1'b1, 1'b1, 3'd7, 11'd9},    // R9
    {1'b0, 1'b1, 3'd2, 11'd385},  // R9 test level alone
    {1'b1, 1'b1, 3'd1, 11'd3}     // R9
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_restart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;   // edge 0 has just sampled the pulse
  endtask

  task automatic set_mode(input logic b, input logic t, input logic [2:0] c);
    @(negedge clk);
    below = b; testlvl = t; tsel = c;
    repeat (3) @(negedge clk);
  endtask

  task automatic time_to_timeout(output int n);
    do_restart();
    n = 0;
    while (!timeout_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic sample_gap(output int gap);
    int w;
    w = 0;
    while (!sample_o && w < 5000) begin @(negedge clk); w++; end
    @(negedge clk);
    gap = 1;
    while (!sample_o && gap < 5000) begin @(negedge clk); gap++; end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    int highs;
    rst = 1'b1; restart = 1'b0; below = 1'b0; testlvl = 1'b0; tsel = 3'd0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 sysclk", int'(sysclk_o), 0);
    chk("R1 sample", int'(sample_o), 0);
    chk("R1 holdoff", int'(holdoff_o), 0);
    chk("R1 timeout", int'(timeout_o), 0);
    rst = 1'b0;

    // R2 duty and period
    repeat (10) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (sysclk_o) highs++;
    end
    chk("R2 sysclk high count", highs, 32);

    // R3 sample periods
    set_mode(1'b0, 1'b0, 3'd0);
    sample_gap(n);
    sample_gap(n);
    chk("R3 sample period normal", n, 512);
    set_mode(1'b0, 1'b1, 3'd0);
    sample_gap(n);
    sample_gap(n);
    chk("R3 sample period test", n, 128);

    // R4 holdoff normal: rises within edges 249..257
    set_mode(1'b0, 1'b0, 3'd0);
    do_restart();
    repeat (240) @(negedge clk);
    chk("R4 holdoff low normal", int'(holdoff_o), 0);
    repeat (20) @(negedge clk);
    chk("R4 holdoff high normal", int'(holdoff_o), 1);
    repeat (100) @(negedge clk);
    chk("R4 holdoff stays high", int'(holdoff_o), 1);
    // R4 holdoff test level: rises within edges 25..33
    set_mode(1'b0, 1'b1, 3'd0);
    do_restart();
    repeat (20) @(negedge clk);
    chk("R4 holdoff low test", int'(holdoff_o), 0);
    repeat (16) @(negedge clk);
    chk("R4 holdoff high test", int'(holdoff_o), 1);

    // R5 R8 R9 limit table
    for (int v = 0; v < 8; v++) begin
      set_mode(VEC[v][15], VEC[v][14], VEC[v][13:11]);
      time_to_timeout(n);
      chk($sformatf("R5/R8/R9 vector %0d edges to timeout", v), n, int'(VEC[v][10:0]));
    end

    // R6 disabled code
    set_mode(1'b1, 1'b1, 3'd0);
    do_restart();
    repeat (60) @(negedge clk);
    chk("R6 code zero no timeout", int'(timeout_o), 0);

    // R7 sticky then cleared
    set_mode(1'b1, 1'b1, 3'd2);
    time_to_timeout(n);
    tsel = 3'd0;
    repeat (20) @(negedge clk);
    chk("R7 timeout sticky", int'(timeout_o), 1);
    do_restart();
    chk("R7 restart clears timeout", int'(timeout_o), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule